// File: doc/BRIEF.md
# Dual-Mode Converter Output Capture

This block sits at the receiving end of the parallel output bus of a 12-bit analog-to-digital converter and rebuilds whole samples from it. A mode pin picks one of two wirings. In full-rate mode all twelve data pins and the overflow pin are taken once per clock period. In double-data-rate mode only six pins carry data. Each of those lanes carries a pair of adjacent bits, with the lower bit in the low half of the clock period and the upper bit in the high half. The block puts each pair back into its place in the word.

The block runs on a capture clock that is the converter's output clock shifted by a quarter period. Its rising edge then falls in the middle of the high phase and its falling edge in the middle of the low phase. In full-rate mode the bus changes at the output clock's falling edge, so the rising capture edge sits well clear of the transitions. The result leaves on a valid-qualified stream: a sample word, an overflow flag that belongs to that word, and a one-cycle valid strobe. A converter cannot be paused, so the stream has no ready input and there is no back-pressure. The consumer must accept a word in every cycle that `smp_valid_o` is high.

Top module: `adc_capture`

## Requirements
- R1: While `rst_n` is low, and at the first rising edge after it goes high, `smp_valid_o`, `smp_word_o` and `smp_ovf_o` are all 0.
- R2: `mode_i` is sampled only while `rst_n` is low (0 = full-rate, 1 = double-data-rate). Changes after reset have no effect on how words are assembled.
- R3: In full-rate mode, each rising edge of `clk` captures `pins_i[11:0]` as one sample, with bit 11 the most significant. Every such edge yields one word.
- R4: In double-data-rate mode, lane k is pin `pins_i[2k+1]`. Sample bit 2k is the lane value at a falling edge of `clk`, and bit 2k+1 is the lane value at the rising edge that follows it.
- R5: In double-data-rate mode, a low-phase half is only paired with the rising edge right after it. A rising edge after reset release with no post-reset falling edge before it yields no word.
- R6: `ovf_i` is sampled at the rising capture edge and leaves in the same cycle as the word it was captured with. `smp_ovf_o` is 0 whenever `smp_valid_o` is 0.
- R7: A word captured at rising edge N appears on `smp_word_o` with `smp_valid_o` high after rising edge N+1, for one cycle per word.
- R8: In double-data-rate mode, the even-numbered pins `pins_i[2k]` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, a quarter-period shifted copy of the converter output clock |
| rst_n | input | 1 | Synchronous active-low reset; the mode is latched while it is low |
| mode_i | input | 1 | 0 = full-rate, 1 = double-data-rate |
| pins_i | input | 12 | Converter data pins |
| ovf_i | input | 1 | Converter overflow/underflow pin |
| smp_valid_o | output | 1 | One-cycle strobe for a complete word |
| smp_word_o | output | 12 | Rebuilt sample |
| smp_ovf_o | output | 1 | Overflow flag that belongs to the word |

## Verification
The bench builds the block with its default of six lanes, which gives the full 12-bit word, so the lane-to-bit mapping is tested at the real width. Random samples make the two halves of each lane differ, so a swap of even and odd bits shows up. Random values on the unused even pins expose any leak from them in double-data-rate mode. Releasing reset just after a falling edge reaches the start-up case in which a rising edge has no valid low half to pair with.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef enum logic {
    CAP_FULL = 1'b0,
    CAP_DDR  = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/adc_lane_merge.sv
module adc_lane_merge
  import adc_cap_pkg::*;
#(
  parameter int LANES = 6,
  localparam int W = 2 * LANES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cap_mode_e    mode,
  input  logic [W-1:0] pins,
  input  logic         ovf,
  output logic         cap_v,
  output logic [W-1:0] cap_word,
  output logic         cap_ovf
);
  // Low-phase half, taken mid low phase on the falling edge
  logic [LANES-1:0] low_half_q;
  logic             low_ok_q;
  logic [W-1:0]     ddr_word;

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      low_half_q <= '0;
      low_ok_q   <= 1'b0;
    end else begin
      low_ok_q <= 1'b1;
      for (int k = 0; k < LANES; k++) low_half_q[k] <= pins[2*k+1];
    end
  end

  // Interleave: lane k gives bit 2k (low phase) and bit 2k+1 (high phase)
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign ddr_word[2*k]   = low_half_q[k];
    assign ddr_word[2*k+1] = pins[2*k+1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_v    <= 1'b0;
      cap_word <= '0;
      cap_ovf  <= 1'b0;
    end else begin
      cap_ovf <= ovf;
      if (mode == CAP_DDR) begin
        cap_v    <= low_ok_q;
        cap_word <= ddr_word;
      end else begin
        cap_v    <= 1'b1;
        cap_word <= pins;
      end
    end
  end
endmodule

// File: rtl/adc_out_stage.sv
module adc_out_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_v,
  input  logic [W-1:0] cap_word,
  input  logic         cap_ovf,
  output logic         smp_valid,
  output logic [W-1:0] smp_word,
  output logic         smp_ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_word  <= '0;
      smp_ovf   <= 1'b0;
    end else begin
      smp_valid <= cap_v;
      smp_ovf   <= cap_v & cap_ovf;
      if (cap_v) smp_word <= cap_word;
    end
  end

  a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v |=> smp_valid);
  a_r7_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_v |=> !smp_valid);
  a_r7_word_follows: assert property (@(posedge clk) disable iff (!rst_n)
    cap_v |=> (smp_word == $past(cap_word)));
  a_r6_ovf_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ovf |-> smp_valid);
endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_cap_pkg::*;
#(
  parameter int LANES = 6,
  localparam int WIDTH = 2 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             ovf_i,
  output logic             smp_valid_o,
  output logic [WIDTH-1:0] smp_word_o,
  output logic             smp_ovf_o
);
  cap_mode_e        mode_q;
  logic             cap_v;
  logic [WIDTH-1:0] cap_word;
  logic             cap_ovf;

  // Mode is a strap: loaded only during reset
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= cap_mode_e'(mode_i);
  end

  a_r2_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));

  adc_lane_merge #(.LANES(LANES)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_q),
    .pins     (pins_i),
    .ovf      (ovf_i),
    .cap_v    (cap_v),
    .cap_word (cap_word),
    .cap_ovf  (cap_ovf)
  );

  adc_out_stage #(.W(WIDTH)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_v     (cap_v),
    .cap_word  (cap_word),
    .cap_ovf   (cap_ovf),
    .smp_valid (smp_valid_o),
    .smp_word  (smp_word_o),
    .smp_ovf   (smp_ovf_o)
  );
endmodule

// File: tb/adc_capture_bench.sv
module adc_capture_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mode_i = 1'b0;
  logic [W-1:0] pins_i = '0;
  logic         ovf_i = 1'b0;
  logic         smp_valid_o;
  logic [W-1:0] smp_word_o;
  logic         smp_ovf_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_capture u_adc_capture (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .pins_i(pins_i),
    .ovf_i(ovf_i), .smp_valid_o(smp_valid_o), .smp_word_o(smp_word_o),
    .smp_ovf_o(smp_ovf_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference model: the mode in force and the word captured at the last edge
  bit         m_ddr;
  bit         pv;
  logic [W-1:0] pw;
  bit         po;

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] lane_pins(logic [W-1:0] w, bit odd, logic [W-1:0] junk);
    logic [W-1:0] p;
    for (int k = 0; k < W/2; k++) begin
      p[2*k]   = junk[2*k];
      p[2*k+1] = odd ? w[2*k+1] : w[2*k];
    end
    return p;
  endfunction

  task automatic check_out(string req);
    chk(smp_valid_o == pv, {req, " valid"}, W'(smp_valid_o), W'(pv));
    if (pv) begin
      chk(smp_word_o == pw, {req, " word"}, smp_word_o, pw);
      chk(smp_ovf_o == po, "R6 ovf", W'(smp_ovf_o), W'(po));
    end else begin
      chk(smp_ovf_o == 1'b0, "R6 ovf idle", W'(smp_ovf_o), '0);
    end
  endtask

  // Called just after a rising edge; ends just after the next rising edge
  task automatic cycle(logic [W-1:0] w, bit o, string req);
    #1;
    if (m_ddr) pins_i = lane_pins(w, 1'b0, W'($urandom));
    else begin pins_i = w; ovf_i = o; end
    @(negedge clk); #2;
    if (m_ddr) begin pins_i = lane_pins(w, 1'b1, W'($urandom)); ovf_i = o; end
    @(posedge clk); #1;
    check_out(req);
    pv = 1; pw = w; po = o;
  endtask

  task automatic do_reset(bit ddr, logic [W-1:0] w0, bit o0);
    rst_n = 0; mode_i = ddr; pins_i = w0; ovf_i = o0;
    repeat (3) @(posedge clk);
    #1;
    chk(!smp_valid_o && smp_word_o == '0 && !smp_ovf_o, "R1 in reset",
        {smp_word_o[W-3:0], smp_valid_o, smp_ovf_o}, '0);
    @(negedge clk); #2;
    rst_n = 1;
    @(posedge clk); #1;
    chk(!smp_valid_o && smp_word_o == '0 && !smp_ovf_o, "R1 first edge",
        {smp_word_o[W-3:0], smp_valid_o, smp_ovf_o}, '0);
    m_ddr = ddr;
    pv = !ddr; pw = w0; po = o0;  // R5: DDR discards the first partial pair
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // Full-rate mode (R3), then a mode pin change that must be ignored (R2)
    do_reset(1'b0, 12'h5A3, 1'b1);
    cycle(12'h800, 1'b0, "R3 msb");
    cycle(12'h001, 1'b1, "R3 lsb");
    for (int i = 0; i < 40; i++) begin
      if (i == 20) mode_i = 1'b1;
      cycle(W'($urandom), 1'($urandom), i >= 20 ? "R2 FR kept" : "R3 random");
    end
    cycle(12'hFFF, 1'b0, "R7 flush");

    // Double-data-rate mode (R4, R5, R8), then a mode pin change (R2)
    do_reset(1'b1, 12'hABC, 1'b1);
    cycle(12'hAAA, 1'b0, "R4 odd bits");
    cycle(12'h555, 1'b1, "R4 even bits");
    for (int i = 0; i < 60; i++) begin
      if (i == 30) mode_i = 1'b0;
      cycle(W'($urandom), 1'($urandom), i >= 30 ? "R2 DDR kept" : "R8 R4 random");
    end
    cycle(12'h000, 1'b0, "R7 flush");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule